// File: doc/BRIEF.md
# Charge and Temperature Accumulator Bank

This block keeps six running totals for a battery monitor. On each periodic measurement tick, a signed current sample is added by magnitude to one of two sides. Negative samples count as discharge and non-negative samples count as charge. Each side has a time counter that counts the ticks spent on that side. A third pair of counters sums a temperature reading and counts the ticks on which it was summed. The reading comes from an internal or an external sensor result, picked by a select input.

Every counter is `ACC_W` bits wide and wraps silently. A host clears any subset of the counters by writing a bit map to a clear register. The host reads each counter one byte at a time over a simple byte-wide register bus. Reading the lowest byte of a counter freezes a copy of the whole counter, so the remaining bytes belong to the same value even if a tick lands between reads.

Top module: `chg_temp_accum`

## Requirements
- R1: After reset every counter is zero, and every counter byte reads 0x00.
- R2: On a cycle with `tick` and `curEn` high and `curRes[15]` = 1, the discharge total (index 0) grows by the absolute value of `curRes`, and the discharge tick count (index 1) grows by 1. The charge counters (indexes 2 and 3) keep their values.
- R3: On a cycle with `tick` and `curEn` high and `curRes[15]` = 0, the charge total (index 2) grows by `curRes`, and the charge tick count (index 3) grows by 1. The discharge counters keep their values.
- R4: The magnitude of the most negative current code 0x8000 is 0x8000.
- R5: On a cycle with `tick` and `tempEn` high, the temperature total (index 4) adds `intTemp` when `tempSel` = 0 and `extTemp` when `tempSel` = 1. The temperature tick count (index 5) grows by 1 on the same edges.
- R6: No counter changes while `tick` is low. The current counters do not change while `curEn` is low, and the temperature counters do not change while `tempEn` is low.
- R7: Each counter wraps modulo 2^ACC_W with no saturation.
- R8: A write to byte address `CLR_ADDR` (default 0x61) clears counter k when data bit k is set. The bits are: bit 0 discharge total, bit 1 discharge ticks, bit 2 charge total, bit 3 charge ticks, bit 4 temperature total, bit 5 temperature ticks. Bits 6 and 7 are ignored, and counters whose bits are zero keep their values.
- R9: A clear and an update on the same clock edge leave the counter at zero. A clear acts only in the cycle of its write.
- R10: Counter k sits at byte addresses `CNT_BASE`+4k to `CNT_BASE`+4k+3 (default base 0x20), least significant byte first. `rdData` presents the addressed byte on the cycle after `rdEn`.
- R11: A read of byte 0 of a counter captures the whole counter. Later reads of bytes 1 to 3 return bytes of that capture, even if the counter has changed since.
- R12: Byte lanes above `ACC_W` bits, and addresses outside the counter window, read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Measurement tick, one cycle per update period |
| curEn | input | 1 | Enables current accumulation |
| tempEn | input | 1 | Enables temperature accumulation |
| tempSel | input | 1 | 0 selects internal temperature, 1 selects external |
| curRes | input | CUR_W | Signed current conversion result |
| intTemp | input | TEMP_W | Internal sensor temperature result |
| extTemp | input | TEMP_W | External sensor temperature result |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, valid the cycle after rdEn |

## Verification
The bench builds the block with `ACC_W` = 24 and leaves the other parameters at their defaults. At that width a discharge sample of 0x8000 wraps the total after 512 ticks, so the wrap-through-zero case fits in a short run. The top byte lane of each counter then has no bits behind it, so the rule that unbacked lanes read zero gets exercised. The snapshot check uses totals that carry into bytes 1 and 2. This way a tick between the byte-0 read and the later reads yields a different live value than the captured one.

// File: rtl/chg_temp_accum_pkg.sv
package chg_temp_accum_pkg;
  localparam int NUM_CNT = 6;
  localparam int SEL_W   = 3;

  // counter slot order: fixes clear-bit positions and register offsets
  typedef enum logic [SEL_W-1:0] {
    SLOT_DIS_SUM  = 3'd0,
    SLOT_DIS_TIME = 3'd1,
    SLOT_CHG_SUM  = 3'd2,
    SLOT_CHG_TIME = 3'd3,
    SLOT_TMP_SUM  = 3'd4,
    SLOT_TMP_TIME = 3'd5
  } slot_e;

  typedef struct packed {
    logic [NUM_CNT-1:0] clr;
    logic               addDis;
    logic               addChg;
    logic               addTemp;
    logic               rdEn;
    logic               rdHit;
    logic               snapLoad;
    logic [SEL_W-1:0]   rdSel;
    logic [1:0]         rdByte;
  } strobe_t;
endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import chg_temp_accum_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    CNT_BASE = 'h20,
  parameter logic [ADDR_W-1:0]    CLR_ADDR = 'h61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              curEn,
  input  logic              tempEn,
  input  logic              curSign,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] WINDOW = ADDR_W'(NUM_CNT * 4);

  logic [ADDR_W-1:0] offs;
  logic              inWindow;
  logic              clrHit;

  always_comb begin
    offs     = addr - CNT_BASE;
    inWindow = (addr >= CNT_BASE) && (offs < WINDOW);
    clrHit   = wrEn && (addr == CLR_ADDR);

    strb          = '0;
    strb.clr      = clrHit ? wrData[NUM_CNT-1:0] : '0;
    strb.addDis   = tick && curEn && curSign;
    strb.addChg   = tick && curEn && !curSign;
    strb.addTemp  = tick && tempEn;
    strb.rdEn     = rdEn;
    strb.rdHit    = inWindow;
    strb.rdSel    = offs[SEL_W+1:2];
    strb.rdByte   = offs[1:0];
    strb.snapLoad = rdEn && inWindow && (offs[1:0] == 2'd0);
  end

  // R8: no clear strobe leaves the control unless a write targets the clear register
  a_r8_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clr != '0) |-> (wrEn && addr == CLR_ADDR));

  // R6: without a tick no update strobe is raised
  a_r6_no_tick_no_update: assert property (@(posedge clk) disable iff (!rstN)
    !tick |-> !(strb.addDis || strb.addChg || strb.addTemp));
endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import chg_temp_accum_pkg::*;
#(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned CUR_W  = 16,
  parameter int unsigned TEMP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CUR_W-1:0]  curRes,
  input  logic [TEMP_W-1:0] intTemp,
  input  logic [TEMP_W-1:0] extTemp,
  input  logic              tempSel,
  output logic [7:0]        rdData
);
  logic [ACC_W-1:0]   cnt    [NUM_CNT];
  logic [ACC_W-1:0]   addVal [NUM_CNT];
  logic [NUM_CNT-1:0] addOn;
  logic [CUR_W-1:0]   curMag;
  logic [TEMP_W-1:0]  tempPick;
  logic [31:0]        liveWord;
  logic [31:0]        snap;

  always_comb begin
    curMag   = curRes[CUR_W-1] ? (~curRes + CUR_W'(1)) : curRes;
    tempPick = tempSel ? extTemp : intTemp;
    addVal[SLOT_DIS_SUM]  = ACC_W'(curMag);
    addVal[SLOT_DIS_TIME] = ACC_W'(1);
    addVal[SLOT_CHG_SUM]  = ACC_W'(curMag);
    addVal[SLOT_CHG_TIME] = ACC_W'(1);
    addVal[SLOT_TMP_SUM]  = ACC_W'(tempPick);
    addVal[SLOT_TMP_TIME] = ACC_W'(1);
    addOn = {strb.addTemp, strb.addTemp, strb.addChg, strb.addChg,
             strb.addDis, strb.addDis};
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cnt[k] <= '0;
      else if (strb.clr[k])  cnt[k] <= '0;
      else if (addOn[k])     cnt[k] <= cnt[k] + addVal[k];
    end

    // R9: a clear wins over any update on the same edge
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
      strb.clr[k] |=> (cnt[k] == '0));

    // R6: a counter with neither clear nor update keeps its value
    a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.clr[k] && !addOn[k]) |=> $stable(cnt[k]));
  end

  // R2 / R3: time counters step by exactly one on their side's updates
  a_r2_dis_time_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addDis && !strb.clr[SLOT_DIS_TIME]) |=>
      (cnt[SLOT_DIS_TIME] == $past(cnt[SLOT_DIS_TIME]) + ACC_W'(1)));
  a_r3_chg_time_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addChg && !strb.clr[SLOT_CHG_TIME]) |=>
      (cnt[SLOT_CHG_TIME] == $past(cnt[SLOT_CHG_TIME]) + ACC_W'(1)));
  a_r5_tmp_time_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addTemp && !strb.clr[SLOT_TMP_TIME]) |=>
      (cnt[SLOT_TMP_TIME] == $past(cnt[SLOT_TMP_TIME]) + ACC_W'(1)));

  always_comb begin
    liveWord = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (strb.rdSel == SEL_W'(i)) liveWord = 32'(cnt[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snap   <= '0;
      rdData <= '0;
    end else begin
      if (strb.snapLoad) snap <= liveWord;
      if (strb.rdEn) begin
        if (!strb.rdHit)              rdData <= '0;
        else if (strb.rdByte == 2'd0) rdData <= liveWord[7:0];
        else                          rdData <= snap[8*strb.rdByte +: 8];
      end
    end
  end

  // R11: the capture taken on a byte-0 read matches the low byte just returned
  a_r11_snap_matches: assert property (@(posedge clk) disable iff (!rstN)
    strb.snapLoad |=> (snap[7:0] == rdData));
endmodule

// File: rtl/chg_temp_accum.sv
module chg_temp_accum
  import chg_temp_accum_pkg::*;
#(
  parameter int unsigned       ACC_W    = 32,
  parameter int unsigned       CUR_W    = 16,
  parameter int unsigned       TEMP_W   = 16,
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CNT_BASE = 'h20,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 'h61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              curEn,
  input  logic              tempEn,
  input  logic              tempSel,
  input  logic [CUR_W-1:0]  curRes,
  input  logic [TEMP_W-1:0] intTemp,
  input  logic [TEMP_W-1:0] extTemp,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);
  strobe_t strb;

  accum_ctrl #(
    .ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE), .CLR_ADDR(CLR_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .curEn(curEn), .tempEn(tempEn),
    .curSign(curRes[CUR_W-1]), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .strb(strb)
  );

  accum_datapath #(
    .ACC_W(ACC_W), .CUR_W(CUR_W), .TEMP_W(TEMP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curRes(curRes),
    .intTemp(intTemp), .extTemp(extTemp), .tempSel(tempSel), .rdData(rdData)
  );
endmodule

// File: tb/chg_temp_accum_tb.sv
module chg_temp_accum_tb;
  localparam int ACC_W = 24;
  localparam logic [31:0] MASK = (32'h1 << ACC_W) - 1;
  localparam logic [7:0] BASE = 8'h20;
  localparam logic [7:0] CLRA = 8'h61;

  logic clk = 0, rstN = 0;
  logic tick = 0, curEn = 0, tempEn = 0, tempSel = 0;
  logic [15:0] curRes = '0, intTemp = '0, extTemp = '0;
  logic rdEn = 0, wrEn = 0;
  logic [7:0] addr = '0, wrData = '0;
  logic [7:0] rdData;

  int total = 0, bad = 0;
  logic [31:0] e [6];

  always #4 clk = ~clk;

  chg_temp_accum #(.ACC_W(ACC_W)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .curEn(curEn), .tempEn(tempEn),
    .tempSel(tempSel), .curRes(curRes), .intTemp(intTemp), .extTemp(extTemp),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdByte(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1;
    @(negedge clk); rdEn = 0; d = rdData;
  endtask

  task automatic rdCnt(input int k, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rdByte(BASE + 8'(4*k + i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic checkAll(input string req);
    logic [31:0] v;
    for (int k = 0; k < 6; k++) begin
      rdCnt(k, v);
      check(req, v, e[k]);
    end
  endtask

  function automatic logic [15:0] mag(input logic [15:0] c);
    return c[15] ? (~c + 16'd1) : c;
  endfunction

  // model update for one tick using current input values
  function automatic void model(input logic [5:0] clr);
    if (curEn && curRes[15])  begin e[0] = (e[0] + mag(curRes)) & MASK; e[1] = (e[1] + 1) & MASK; end
    if (curEn && !curRes[15]) begin e[2] = (e[2] + mag(curRes)) & MASK; e[3] = (e[3] + 1) & MASK; end
    if (tempEn) begin
      e[4] = (e[4] + (tempSel ? extTemp : intTemp)) & MASK; e[5] = (e[5] + 1) & MASK;
    end
    for (int k = 0; k < 6; k++) if (clr[k]) e[k] = 0;
  endfunction

  task automatic doTick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    model(6'h00);
  endtask

  task automatic doClear(input logic [7:0] bits, input logic withTick);
    @(negedge clk); wrEn = 1; addr = CLRA; wrData = bits; tick = withTick;
    @(negedge clk); wrEn = 0; tick = 0;
    if (withTick) model(bits[5:0]);
    else for (int k = 0; k < 6; k++) if (bits[k]) e[k] = 0;
  endtask

  task automatic t_reset();
    checkAll("R1 reset");
  endtask

  task automatic t_discharge();
    curEn = 1; curRes = -16'sd100;
    repeat (3) doTick();
    check("R2 discharge sum", e[0], 32'd300);
    checkAll("R2 discharge");
  endtask

  task automatic t_charge();
    curRes = 16'd250;
    repeat (2) doTick();
    check("R3 charge sum", e[2], 32'd500);
    checkAll("R3 charge");
  endtask

  task automatic t_magnitude();
    curRes = 16'h8000;
    doTick();
    check("R4 min code magnitude", e[0], 32'd300 + 32'h8000);
    checkAll("R4 magnitude");
  endtask

  task automatic t_temperature();
    curEn = 0; tempEn = 1; intTemp = 16'd300; extTemp = 16'd500;
    tempSel = 0; doTick();
    tempSel = 1; doTick();
    check("R5 temp sum", e[4], 32'd800);
    checkAll("R5 temperature");
  endtask

  task automatic t_gating();
    tempEn = 0; curEn = 0; curRes = 16'd77;
    doTick();
    curEn = 1; tempEn = 1;
    repeat (4) @(negedge clk);
    curEn = 0; tempEn = 0;
    checkAll("R6 gating");
  endtask

  task automatic t_clear_map();
    doClear(8'h04, 0);
    checkAll("R8 clear charge sum only");
    doClear(8'hC0, 0);
    checkAll("R8 upper bits ignored");
  endtask

  task automatic t_clear_vs_tick();
    curEn = 1; curRes = 16'hFF00; tempEn = 1;
    doClear(8'h11, 1);
    check("R9 clear beats tick", e[0], 32'd0);
    checkAll("R9 clear priority");
    curEn = 0; tempEn = 0;
  endtask

  task automatic t_wrap();
    doClear(8'h3F, 0);
    curEn = 1; curRes = 16'h8000;
    repeat (512) doTick();
    check("R7 wrap to zero", e[0], 32'd0);
    checkAll("R7 wrap");
    doTick();
    checkAll("R7 after wrap");
    curEn = 0;
  endtask

  task automatic t_snapshot();
    logic [7:0] b;
    doClear(8'h3F, 0);
    curEn = 1; curRes = 16'h8000;
    repeat (3) doTick();
    rdByte(BASE, b);
    check("R11 byte0", 32'(b), 32'h00);
    doTick();
    rdByte(BASE + 8'd1, b); check("R11 snapshot byte1", 32'(b), 32'h80);
    rdByte(BASE + 8'd2, b); check("R11 snapshot byte2", 32'(b), 32'h01);
    rdByte(BASE + 8'd3, b); check("R12 unbacked lane", 32'(b), 32'h00);
    rdByte(BASE, b);
    rdByte(BASE + 8'd2, b); check("R10 fresh byte2", 32'(b), 32'h02);
    rdByte(8'h38, b); check("R12 past window", 32'(b), 32'h00);
    rdByte(8'h40, b); check("R12 unmapped", 32'(b), 32'h00);
    curEn = 0;
  endtask

  initial begin
    for (int k = 0; k < 6; k++) e[k] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_discharge();
    t_charge();
    t_magnitude();
    t_temperature();
    t_gating();
    t_clear_map();
    t_clear_vs_tick();
    t_wrap();
    t_snapshot();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule